// File: doc/BRIEF.md
# Multichannel Scan Sequencer

This block decides which analog input the multiplexer presents to the converter in every frame of a serial sampling link. The serial engine around it supplies three strobes: the start of a frame, each falling serial-clock edge, and a marker that the 16-bit command word shifted in during the frame is complete. The sequencer decodes that word, keeps the scan program, and moves the multiplexer select at one fixed edge inside each frame.

The block has three selection policies. In directed selection, each frame names the channel for the next frame. In masked scanning, a 16-bit enable mask is walked upward one channel per frame. In bounded scanning, channels 0 up to a programmed last channel are visited in turn. A channel acquired in one frame is sampled when the next frame starts, and its result is shifted out during that frame. The block therefore also carries a channel tag, aligned to the data being returned, and a flag that is low for the first frame after reset.

Top module: `scan_sequencer`

## Requirements
- R1: `mux_sel` changes only on the second `sclk_fall` strobe after a `frame_start` strobe, and holds for the rest of the frame.
- R2: On each `frame_start`, `tag_ch` takes the value `mux_sel` had during the frame that just ended. `tag_valid` is 0 for the first frame after reset and 1 for every frame after that.
- R3: A command word with code 0001 in bits [15:12] selects directed mode, with the channel in bits [10:7]. In directed mode, that channel drives `mux_sel` from the second edge of the next frame.
- R4: Code 0010 selects masked scanning. At each select edge the next channel is the lowest enabled channel above the current one. If none is above, it is the lowest enabled channel. An all-zero mask gives channel 0.
- R5: A word with code 1000 arms mask loading. The whole word of the next frame becomes the mask, bit i enabling channel i. Neither of these two frames changes the mode. The mask resets to 0xFFFF.
- R6: Code 0011 selects bounded scanning: the next channel is current+1, or 0 when the current channel is at or above the last channel. A word with code 1001 loads the last channel from bits [9:6]. The last channel resets to 15.
- R7: While reset is held low, the block is in directed mode on channel 0, with `mux_sel` = 0, `tag_ch` = 0 and `tag_valid` = 0.
- R8: Mode changes leave the mask and last-channel values as they are. Re-entering a scan mode resumes with the stored program.
- R9: A mode request takes effect from the frame after the one that carries it. The select edge of the carrying frame still steps by the old mode.
- R10: Any other code (for example 0000 or 0101), outside a mask frame, changes neither the mode nor any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of a frame (sample instant) |
| sclk_fall | input | 1 | One-cycle strobe per falling serial-clock edge |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_word` holds the completed frame's input word |
| cmd_word | input | 16 | Command word received during the frame |
| mux_sel | output | 4 | Multiplexer channel select |
| tag_ch | output | 4 | Channel of the sample being returned in this frame |
| tag_valid | output | 1 | Returned sample is meaningful (low in the first frame) |

## Verification
The bench builds the block with its defaults: 16 channels, a 16-bit word and the select edge on the second falling strobe. At this size a 4-bit channel field fills the word layout exactly, and the wrap from channel 15 back to 0 in both scan modes is reached in a few dozen frames. Random command streams mix mode switches, mask loads (including an all-zero mask) and last-channel loads with junk codes, so that carried-over program values and switches between modes in mid-scan happen often.

// File: rtl/scan_seq_pkg.sv
// Shared types and command codes of the scan sequencer.
// Assumes the command code sits in the top four bits of the input word.
package scan_seq_pkg;
    typedef enum logic [1:0] {
        SEL_DIRECT = 2'd0,
        SEL_MASKED = 2'd1,
        SEL_BOUNDED = 2'd2
    } sel_mode_e;

    localparam logic [3:0] OP_DIRECT  = 4'b0001;
    localparam logic [3:0] OP_MASKED  = 4'b0010;
    localparam logic [3:0] OP_BOUNDED = 4'b0011;
    localparam logic [3:0] OP_ARM_MASK = 4'b1000;
    localparam logic [3:0] OP_SET_LAST = 4'b1001;
endpackage

// File: rtl/seq_frame_timer.sv
// Counts falling serial-clock strobes within a frame and flags the select edge.
// Assumes frame_start and sclk_fall never share a cycle.
module seq_frame_timer #(
    parameter int FRAME_BITS = 16,
    parameter int SEL_EDGE   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic sclk_fall,
    output logic sel_strobe
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(SEL_EDGE - 1);

    logic [CNT_W-1:0] edge_cnt;

    // Edge counter: cleared at frame start, saturates at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (frame_start) begin
            edge_cnt <= '0;
        end else if (sclk_fall && edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign sel_strobe = sclk_fall && (edge_cnt == CNT_HIT);
endmodule

// File: rtl/seq_cfg_regs.sv
// Decodes each completed command word into mode, directed channel, scan mask
// and last channel. A mask-arm word makes the next whole word the mask.
// Assumes cmd_valid pulses once per frame, after the last input bit.
module seq_cfg_regs
    import scan_seq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int WORD_W = 16,
    localparam int CW    = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output sel_mode_e         mode,
    output logic [CW-1:0]     direct_ch,
    output logic [NCH-1:0]    scan_mask,
    output logic [CW-1:0]     last_ch
);
    localparam int DIRECT_LSB = 7;
    localparam int LAST_LSB   = 6;

    logic [3:0] opcode;
    logic       arm_q;

    assign opcode = cmd_word[WORD_W-1 -: 4];

    // Command decode and program register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= SEL_DIRECT;
            direct_ch <= '0;
            scan_mask <= '1;
            last_ch   <= CW'(NCH - 1);
            arm_q     <= 1'b0;
        end else if (cmd_valid) begin
            if (arm_q) begin
                scan_mask <= cmd_word[NCH-1:0];
                arm_q     <= 1'b0;
            end else begin
                case (opcode)
                    OP_DIRECT: begin
                        mode      <= SEL_DIRECT;
                        direct_ch <= cmd_word[DIRECT_LSB +: CW];
                    end
                    OP_MASKED:   mode    <= SEL_MASKED;
                    OP_BOUNDED:  mode    <= SEL_BOUNDED;
                    OP_ARM_MASK: arm_q   <= 1'b1;
                    OP_SET_LAST: last_ch <= cmd_word[LAST_LSB +: CW];
                    default: ;
                endcase
            end
        end
    end

    // Loading the mask word leaves the mode alone and disarms (R5).
    assert_mask_frame_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && cmd_valid) |=> ($stable(mode) && !arm_q));

    // Programming the last channel leaves the mode alone (R8).
    assert_setlast_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && cmd_valid && opcode == OP_SET_LAST) |=> $stable(mode));
endmodule

// File: rtl/seq_next_ch.sv
// Computes the channel to select at the next select edge for the current mode.
// Purely combinational; the caller registers the result.
module seq_next_ch
    import scan_seq_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  sel_mode_e      mode,
    input  logic [CW-1:0]  cur_ch,
    input  logic [CW-1:0]  direct_ch,
    input  logic [NCH-1:0] scan_mask,
    input  logic [CW-1:0]  last_ch,
    output logic [CW-1:0]  next_ch
);
    logic [NCH-1:0] above;
    logic [CW-1:0]  first_above;
    logic [CW-1:0]  first_any;
    logic           has_above;
    logic [CW-1:0]  masked_ch;
    logic [CW-1:0]  bounded_ch;

    // Enabled channels strictly above the current one.
    for (genvar g = 0; g < NCH; g++) begin : g_above
        assign above[g] = scan_mask[g] && (cur_ch < CW'(g));
    end

    // Lowest set bit of each vector; scanning downward lets the lowest win.
    always_comb begin
        first_above = '0;
        first_any   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (above[i])     first_above = CW'(i);
            if (scan_mask[i]) first_any   = CW'(i);
        end
    end

    assign has_above  = |above;
    assign masked_ch  = has_above ? first_above : first_any;
    assign bounded_ch = (cur_ch >= last_ch) ? '0 : cur_ch + 1'b1;

    // Mode selects the policy.
    always_comb begin
        case (mode)
            SEL_MASKED:  next_ch = masked_ch;
            SEL_BOUNDED: next_ch = bounded_ch;
            default:     next_ch = direct_ch;
        endcase
    end
endmodule

// File: rtl/scan_sequencer.sv
// Top of the scan sequencer: registers the multiplexer select at the select
// edge and pipelines the channel tag to the frame that returns its sample.
// Assumes the serial engine supplies single-cycle strobes in the clk domain.
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int WORD_W     = 16,
    parameter int FRAME_BITS = 16,
    parameter int SEL_EDGE   = 2,
    localparam int CW        = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sclk_fall,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [CW-1:0]     mux_sel,
    output logic [CW-1:0]     tag_ch,
    output logic              tag_valid
);
    sel_mode_e      mode;
    logic [CW-1:0]  direct_ch;
    logic [NCH-1:0] scan_mask;
    logic [CW-1:0]  last_ch;
    logic [CW-1:0]  next_ch;
    logic           sel_strobe;
    logic           seen_frame;
    logic           sel_enabled;

    seq_frame_timer #(.FRAME_BITS(FRAME_BITS), .SEL_EDGE(SEL_EDGE)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sclk_fall(sclk_fall), .sel_strobe(sel_strobe)
    );

    seq_cfg_regs #(.NCH(NCH), .WORD_W(WORD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .mode(mode), .direct_ch(direct_ch), .scan_mask(scan_mask), .last_ch(last_ch)
    );

    seq_next_ch #(.NCH(NCH)) u_next (
        .mode(mode), .cur_ch(mux_sel), .direct_ch(direct_ch),
        .scan_mask(scan_mask), .last_ch(last_ch), .next_ch(next_ch)
    );

    // Multiplexer select register, moved only at the select edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mux_sel <= '0;
        else if (sel_strobe) mux_sel <= next_ch;
    end

    // Tag pipeline: the channel acquired last frame is sampled now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_ch     <= '0;
            tag_valid  <= 1'b0;
            seen_frame <= 1'b0;
        end else if (frame_start) begin
            tag_ch     <= mux_sel;
            tag_valid  <= seen_frame;
            seen_frame <= 1'b1;
        end
    end

    assign sel_enabled = scan_mask[mux_sel];

    assert_sel_only_at_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> $past(sel_strobe));

    assert_tag_follows_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tag_ch == $past(mux_sel)));

    assert_direct_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && mode == SEL_DIRECT) |=> (mux_sel == $past(direct_ch)));

    assert_masked_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && mode == SEL_MASKED && (|scan_mask) && !cmd_valid) |=> sel_enabled);

    assert_bounded_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && mode == SEL_BOUNDED) |=> (mux_sel == '0 || mux_sel == $past(mux_sel) + 1'b1));

    assert_reset_state_R7: assert property (@(posedge clk)
        !rst_n |=> (mux_sel == '0 && tag_ch == '0 && !tag_valid));
endmodule

// File: tb/scan_sequencer_test.sv
// Self-checking bench: directed scenarios followed by seeded random frames,
// compared against a reference model kept in bench functions.
module scan_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        sclk_fall = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [3:0]  mux_sel;
    logic [3:0]  tag_ch;
    logic        tag_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference model state
    int        m_mode;      // 0 directed, 1 masked, 2 bounded
    int        m_direct;
    bit [15:0] m_mask;
    int        m_last;
    bit        m_arm;
    int        m_sel;
    bit        m_seen;

    scan_sequencer uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sclk_fall(sclk_fall),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .mux_sel(mux_sel), .tag_ch(tag_ch), .tag_valid(tag_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_next(input int cur);
        if (m_mode == 1) begin
            for (int k = 1; k <= 16; k++)
                if (m_mask[(cur + k) % 16]) return (cur + k) % 16;
            return 0;
        end
        if (m_mode == 2) return (cur >= m_last) ? 0 : cur + 1;
        return m_direct;
    endfunction

    function automatic void model_cmd(input bit [15:0] w);
        if (m_arm) begin
            m_mask = w;
            m_arm  = 0;
        end else begin
            case (w[15:12])
                4'b0001: begin m_mode = 0; m_direct = int'(w[10:7]); end
                4'b0010: m_mode = 1;
                4'b0011: m_mode = 2;
                4'b1000: m_arm = 1;
                4'b1001: m_last = int'(w[9:6]);
                default: ;
            endcase
        end
    endfunction

    function automatic string mode_req();
        if (m_mode == 1) return "R4";
        if (m_mode == 2) return "R6";
        return "R3";
    endfunction

    // One complete frame; sel_label overrides the requirement named for the select check.
    task automatic run_frame(input bit [15:0] w, input string sel_label);
        string lbl;
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        check("R2 tag", int'(tag_ch), m_sel);
        check("R2 valid", int'(tag_valid), int'(m_seen));
        m_seen = 1;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk) sclk_fall = 1'b1;
            @(negedge clk) sclk_fall = 1'b0;
            if (i == 1) check("R1 before edge", int'(mux_sel), m_sel);
            if (i == 2) begin
                lbl = (sel_label.len() != 0) ? sel_label : mode_req();
                m_sel = model_next(m_sel);
                check(lbl, int'(mux_sel), m_sel);
            end
            if (i == 16) check("R1 hold", int'(mux_sel), m_sel);
        end
        @(negedge clk) begin cmd_valid = 1'b1; cmd_word = w; end
        @(negedge clk) cmd_valid = 1'b0;
        model_cmd(w);
    endtask

    function automatic bit [15:0] op(input bit [3:0] code, input bit [11:0] rest);
        return {code, rest};
    endfunction

    initial begin
        #(100000 * 20);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit [15:0] w;
        int r;
        void'($urandom(32'h5EC0));
        m_mode = 0; m_direct = 0; m_mask = 16'hFFFF; m_last = 15; m_arm = 0; m_sel = 0; m_seen = 0;
        repeat (4) @(negedge clk);
        check("R7 sel", int'(mux_sel), 0);
        check("R7 tag", int'(tag_ch), 0);
        check("R7 valid", int'(tag_valid), 0);
        @(negedge clk) rst_n = 1'b1;

        // Directed selection: channels 5, 9, 15, 0
        run_frame(op(4'b0001, 12'(5 << 7)), "R7 first frame");
        run_frame(op(4'b0001, 12'(9 << 7)), "");
        run_frame(op(4'b0001, 12'(15 << 7)), "");
        run_frame(op(4'b0001, 12'(0)), "");
        run_frame(16'h0000, "");

        // Masked scan with reset mask: all channels, wrap 15 -> 0
        run_frame(op(4'b0010, 12'h000), "R9 old mode");
        for (int i = 0; i < 18; i++) run_frame(16'h0000, "R4 reset mask");

        // Program mask to channels 0,5,10,15 while scanning
        run_frame(op(4'b1000, 12'h000), "R5 arm frame");
        run_frame(16'h8421, "R5 mask frame");
        for (int i = 0; i < 6; i++) run_frame(16'h0000, "R4");

        // Switch to directed mid-scan, then back: mask must survive
        run_frame(op(4'b0001, 12'(3 << 7)), "R9 switch frame");
        run_frame(16'h0000, "R9 commanded");
        run_frame(op(4'b0010, 12'h000), "");
        for (int i = 0; i < 5; i++) run_frame(16'h0000, "R8 mask kept");

        // Junk codes while scanning
        run_frame(op(4'b0101, 12'hFFF), "");
        run_frame(op(4'b0000, 12'h3C0), "R10 junk");
        run_frame(16'h0000, "R10 junk");

        // All-zero mask gives channel 0
        run_frame(op(4'b1000, 12'h000), "");
        run_frame(16'h0000, "");
        for (int i = 0; i < 3; i++) run_frame(16'h0000, "R4 zero mask");

        // Bounded scan with last = 5, wrap 5 -> 0
        run_frame(op(4'b1001, 12'(5 << 6)), "");
        run_frame(op(4'b0011, 12'h000), "");
        for (int i = 0; i < 14; i++) run_frame(16'h0000, "R6");
        run_frame(op(4'b0001, 12'(12 << 7)), "");
        run_frame(op(4'b0011, 12'h000), "");
        run_frame(16'h0000, "R6 above last");
        run_frame(16'h0000, "R8 last kept");

        // Seeded random command stream
        for (int f = 0; f < 300; f++) begin
            r = int'($urandom_range(0, 9));
            w = 16'($urandom());
            case (r)
                0, 1: w[15:12] = 4'b0001;
                2:    w[15:12] = 4'b0010;
                3:    w[15:12] = 4'b0011;
                4:    w[15:12] = 4'b1000;
                5:    w[15:12] = 4'b1001;
                6:    w[15:12] = 4'b0000;
                default: ;
            endcase
            run_frame(w, "");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule